// File: doc/BRIEF.md
# NAND Address Cycle Sequencer

This block converts a single addressing request into the series of byte-wide address cycles that a NAND flash device expects after a command byte. A request may carry a column part, a page part, both, or neither. The column part always goes out as zero bytes, because the surrounding controller moves whole pages and tracks the byte offset inside its own buffer. The page part is cut into bytes from the least significant end. How many cycles are produced depends on the page geometry (small 512-byte pages or large 2048-byte pages) and on two device-size flags.

An operation engine consumes the bytes one at a time through a valid/ready handshake. The engine raises ready once it has finished driving a cycle on the flash bus. The sequencer latches the request when it accepts a start pulse, so the requester may change its inputs while the cycles are in flight. When the last byte has been taken, or at once when the request has neither part, the sequencer gives a one-cycle done pulse.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset, `cyc_valid_o`, `done_o` and `busy_o` are all 0.
- R2: A request with the column flag set first issues column bytes of value 0x00: one for small pages (`large_page_i`=0) and two for large pages (`large_page_i`=1).
- R3: A request with the page flag set issues page address bits 7:0 as its first page byte and bits 15:8 as its second, for both page sizes.
- R4: For large pages a third page byte (bits 23:16) is issued only when `dens_256m_i`=1; `dens_64m_i` has no effect on large pages.
- R5: For small pages a third page byte (bits 23:16) is issued only when `dens_64m_i`=1; `dens_256m_i` has no effect on small pages.
- R6: All column bytes come before all page bytes, page bytes go out from least to most significant, and no byte beyond the computed count is issued.
- R7: While `cyc_valid_o`=1 and `cyc_ready_i`=0, the byte on `cyc_byte_o` is held and the sequence does not advance.
- R8: `done_o` is a one-cycle pulse in the cycle after the final byte is accepted, or in the cycle after start when neither flag is set; `cyc_valid_o` is 0 while `done_o`=1.
- R9: A start pulse while `busy_o`=1 is ignored: the running byte stream and its done timing are unchanged.
- R10: Request inputs are captured at the accepted start; changing `page_addr_i` afterwards does not alter the bytes issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken when idle |
| col_vld_i | input | 1 | Request contains a column part |
| page_vld_i | input | 1 | Request contains a page part |
| page_addr_i | input | 24 | Page address of the request |
| large_page_i | input | 1 | 1 = 2048-byte pages, 0 = 512-byte pages |
| dens_64m_i | input | 1 | Device holds 64 MiB or more |
| dens_256m_i | input | 1 | Device holds 256 MiB or more |
| cyc_valid_o | output | 1 | An address byte is offered |
| cyc_ready_i | input | 1 | Engine has completed the offered cycle |
| cyc_byte_o | output | 8 | Offered address byte |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bound checker watches on every cycle that an offered byte stays put under back-pressure, that done is a lone pulse never overlapping an offered byte, that an empty request finishes in the next cycle, and that the first byte after a start is zero for a column request or the low page byte otherwise. The cycle count per geometry and density, the full ordering of the stream, the capture of the address at start and the rejection of a start while busy only show up in the bench, which sweeps every flag combination under three ready patterns and compares each accepted byte with a stream computed from the requirements.

// File: rtl/nand_addr_pkg.sv
package nand_addr_pkg;
   // width of one address cycle on the flash bus
   localparam int unsigned CYC_W     = 8;
   // largest number of column cycles a request can produce
   localparam int unsigned COL_SLOTS = 2;

   // kind of an issue slot, used by the slot planner
   typedef enum logic [1:0] {
      SLOT_COL_FIRST = 2'd0,
      SLOT_COL_WIDE  = 2'd1,
      SLOT_PG_BASE   = 2'd2,
      SLOT_PG_DENSE  = 2'd3
   } slot_kind_e;

   function automatic slot_kind_e kind_of(input int unsigned idx, input int unsigned col_slots);
      if (idx == 0 && col_slots > 0)  return SLOT_COL_FIRST;
      if (idx < col_slots)            return SLOT_COL_WIDE;
      if (idx < col_slots + 2)        return SLOT_PG_BASE;
      return SLOT_PG_DENSE;
   endfunction
endpackage

// File: rtl/nand_addr_plan.sv
module nand_addr_plan
   import nand_addr_pkg::*;
#(
   parameter int unsigned COL_N   = COL_SLOTS,
   parameter int unsigned PAGE_N  = 3,
   localparam int unsigned SLOT_N = COL_N + PAGE_N
) (
   input  logic              col_vld_i,
   input  logic              page_vld_i,
   input  logic              large_page_i,
   input  logic              dens_64m_i,
   input  logic              dens_256m_i,
   output logic [SLOT_N-1:0] slot_en_o
);
   logic dense_ok;
   // density threshold depends on page geometry
   assign dense_ok = large_page_i ? dens_256m_i : dens_64m_i;

   for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
      localparam slot_kind_e KIND = kind_of(s, COL_N);
      if (KIND == SLOT_COL_FIRST) begin : g_c0
         assign slot_en_o[s] = col_vld_i;
      end else if (KIND == SLOT_COL_WIDE) begin : g_cw
         assign slot_en_o[s] = col_vld_i & large_page_i;
      end else if (KIND == SLOT_PG_BASE) begin : g_pb
         assign slot_en_o[s] = page_vld_i;
      end else begin : g_pd
         assign slot_en_o[s] = page_vld_i & dense_ok;
      end
   end
endmodule

// File: rtl/nand_addr_pick.sv
module nand_addr_pick #(
   parameter int unsigned W = 5
) (
   input  logic [W-1:0] pend_i,
   output logic [W-1:0] sel_o,
   output logic [W-1:0] rest_o,
   output logic         last_o
);
   logic [W-1:0] neg;
   // two's complement isolates the lowest pending slot
   assign neg    = ~pend_i + {{(W-1){1'b0}}, 1'b1};
   assign sel_o  = pend_i & neg;
   assign rest_o = pend_i & ~sel_o;
   assign last_o = (rest_o == '0);
endmodule

// File: rtl/nand_addr_bytemux.sv
module nand_addr_bytemux #(
   parameter int unsigned BYTE_W  = 8,
   parameter int unsigned PAGE_N  = 3,
   localparam int unsigned ADDR_W = BYTE_W * PAGE_N
) (
   input  logic [PAGE_N-1:0] page_sel_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [BYTE_W-1:0] byte_o
);
   // column slots contribute nothing, so an idle or column select yields zero
   always_comb begin
      byte_o = '0;
      for (int k = 0; k < PAGE_N; k++) begin
         byte_o = byte_o | ({BYTE_W{page_sel_i[k]}} & addr_i[k*BYTE_W +: BYTE_W]);
      end
   end
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
   import nand_addr_pkg::*;
#(
   parameter int unsigned BYTE_W  = CYC_W,
   parameter int unsigned PAGE_AW = 24,
   parameter int unsigned COL_N   = COL_SLOTS,
   localparam int unsigned PAGE_N = PAGE_AW / BYTE_W,
   localparam int unsigned SLOT_N = COL_N + PAGE_N
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               col_vld_i,
   input  logic               page_vld_i,
   input  logic [PAGE_AW-1:0] page_addr_i,
   input  logic               large_page_i,
   input  logic               dens_64m_i,
   input  logic               dens_256m_i,
   output logic               cyc_valid_o,
   input  logic               cyc_ready_i,
   output logic [BYTE_W-1:0]  cyc_byte_o,
   output logic               done_o,
   output logic               busy_o
);
   if (PAGE_AW != PAGE_N * BYTE_W) begin : g_bad_aw
      $error("page address width must be a whole number of cycles");
   end
   if (PAGE_N < 2) begin : g_bad_pn
      $error("at least two page cycles are required");
   end
   if (COL_N < 1) begin : g_bad_cn
      $error("at least one column cycle is required");
   end

   logic [SLOT_N-1:0]  plan_en;
   logic [SLOT_N-1:0]  pend_q;
   logic [SLOT_N-1:0]  sel;
   logic [SLOT_N-1:0]  rest;
   logic               last;
   logic [PAGE_AW-1:0] addr_q;
   logic               done_q;
   logic               take_req;
   logic               accept;

   nand_addr_plan #(.COL_N(COL_N), .PAGE_N(PAGE_N)) plan_i (
      .col_vld_i    (col_vld_i),
      .page_vld_i   (page_vld_i),
      .large_page_i (large_page_i),
      .dens_64m_i   (dens_64m_i),
      .dens_256m_i  (dens_256m_i),
      .slot_en_o    (plan_en)
   );

   nand_addr_pick #(.W(SLOT_N)) pick_i (
      .pend_i (pend_q),
      .sel_o  (sel),
      .rest_o (rest),
      .last_o (last)
   );

   nand_addr_bytemux #(.BYTE_W(BYTE_W), .PAGE_N(PAGE_N)) mux_i (
      .page_sel_i (sel[SLOT_N-1:COL_N]),
      .addr_i     (addr_q),
      .byte_o     (cyc_byte_o)
   );

   assign busy_o      = |pend_q;
   assign cyc_valid_o = busy_o;
   assign take_req    = start_i & ~busy_o;
   assign accept      = busy_o & cyc_ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         addr_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (take_req) begin
            pend_q <= plan_en;
            addr_q <= page_addr_i;
            if (plan_en == '0) done_q <= 1'b1;
         end else if (accept) begin
            pend_q <= rest;
            if (last) done_q <= 1'b1;
         end
      end
   end

   assign done_o = done_q;
endmodule

// File: rtl/nand_addr_seq_chk.sv
module nand_addr_seq_chk #(
   parameter int unsigned BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              col_vld_i,
   input logic              page_vld_i,
   input logic [BYTE_W-1:0] addr_lo_i,
   input logic              cyc_valid_o,
   input logic              cyc_ready_i,
   input logic [BYTE_W-1:0] cyc_byte_o,
   input logic              done_o,
   input logic              busy_o
);
   // R7
   hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid_o && !cyc_ready_i |=> cyc_valid_o && $stable(cyc_byte_o));

   // R8
   done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_not_offering_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !cyc_valid_o && !busy_o);

   // R8
   empty_req_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && !col_vld_i && !page_vld_i |=> done_o && !cyc_valid_o);

   // R2
   col_first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && col_vld_i |=> cyc_valid_o && (cyc_byte_o == '0));

   // R3
   page_first_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && !col_vld_i && page_vld_i
      |=> cyc_valid_o && (cyc_byte_o == $past(addr_lo_i)));
endmodule

bind nand_addr_seq nand_addr_seq_chk #(.BYTE_W(BYTE_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .col_vld_i   (col_vld_i),
   .page_vld_i  (page_vld_i),
   .addr_lo_i   (page_addr_i[BYTE_W-1:0]),
   .cyc_valid_o (cyc_valid_o),
   .cyc_ready_i (cyc_ready_i),
   .cyc_byte_o  (cyc_byte_o),
   .done_o      (done_o),
   .busy_o      (busy_o)
);

// File: tb/nand_addr_seq_tb_top.sv
module nand_addr_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        col_vld_i = 1'b0;
   logic        page_vld_i = 1'b0;
   logic [23:0] page_addr_i = '0;
   logic        large_page_i = 1'b0;
   logic        dens_64m_i = 1'b0;
   logic        dens_256m_i = 1'b0;
   logic        cyc_valid_o;
   logic        cyc_ready_i = 1'b0;
   logic [7:0]  cyc_byte_o;
   logic        done_o;
   logic        busy_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc_cnt  = 0;

   always #5 clk = ~clk;

   nand_addr_seq dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .col_vld_i    (col_vld_i),
      .page_vld_i   (page_vld_i),
      .page_addr_i  (page_addr_i),
      .large_page_i (large_page_i),
      .dens_64m_i   (dens_64m_i),
      .dens_256m_i  (dens_256m_i),
      .cyc_valid_o  (cyc_valid_o),
      .cyc_ready_i  (cyc_ready_i),
      .cyc_byte_o   (cyc_byte_o),
      .done_o       (done_o),
      .busy_o       (busy_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // one request, stream compared against a model built from R2..R6
   task automatic run_req(input logic col, input logic pg, input logic lg,
                          input logic m64, input logic m256,
                          input logic [23:0] addr, input int mode);
      logic [7:0] exp_b [5];
      string      exp_t [5];
      int         n = 0;
      int         idx = 0;
      int         guard = 0;
      logic       stalled = 1'b0;
      logic       poked = 1'b0;
      int         ncol = col ? (lg ? 2 : 1) : 0;
      int         npg  = pg ? (2 + ((lg ? m256 : m64) ? 1 : 0)) : 0;
      for (int c = 0; c < ncol; c++) begin
         exp_b[n] = 8'h00; exp_t[n] = "R2"; n++;
      end
      for (int p = 0; p < npg; p++) begin
         exp_b[n] = addr[p*8 +: 8];
         exp_t[n] = (p < 2) ? "R3" : (lg ? "R4" : "R5");
         n++;
      end
      @(negedge clk);
      start_i = 1'b1; col_vld_i = col; page_vld_i = pg; page_addr_i = addr;
      large_page_i = lg; dens_64m_i = m64; dens_256m_i = m256; cyc_ready_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      page_addr_i = ~addr;   // R10: the captured address must be used
      col_vld_i = ~col; page_vld_i = ~pg; large_page_i = ~lg;
      if (n == 0) begin
         check("R8 empty done", {31'd0, done_o}, 32'd1);
         check("R8 empty valid", {31'd0, cyc_valid_o}, 32'd0);
      end else begin
         while (idx < n && guard < 64) begin
            logic rdy;
            guard++;
            cyc_cnt++;
            check("R6 valid while pending", {31'd0, cyc_valid_o}, 32'd1);
            if (poked)        check({"R9 ", exp_t[idx]}, {24'd0, cyc_byte_o}, {24'd0, exp_b[idx]});
            else if (stalled) check({"R7 ", exp_t[idx]}, {24'd0, cyc_byte_o}, {24'd0, exp_b[idx]});
            else              check({"R10 ", exp_t[idx]}, {24'd0, cyc_byte_o}, {24'd0, exp_b[idx]});
            check("R8 no done mid-stream", {31'd0, done_o}, 32'd0);
            case (mode)
               0:       rdy = 1'b1;
               1:       rdy = cyc_cnt[0];
               default: rdy = ((cyc_cnt % 3) == 2);
            endcase
            cyc_ready_i = rdy;
            poked = 1'b0;
            if (!rdy && mode == 2) begin
               // R9: start while busy with a different request
               start_i = 1'b1; col_vld_i = 1'b0; page_vld_i = 1'b1;
               large_page_i = 1'b1; dens_256m_i = 1'b1; page_addr_i = 24'h5A5A5A;
               poked = 1'b1;
            end
            stalled = ~rdy;
            if (rdy) idx++;
            @(negedge clk);
            start_i = 1'b0;
         end
         cyc_ready_i = 1'b0;
         check("R8 done after last", {31'd0, done_o}, 32'd1);
         check("R6 no extra byte", {31'd0, cyc_valid_o}, 32'd0);
      end
      @(negedge clk);
      check("R8 done pulse width", {31'd0, done_o}, 32'd0);
      check("R9 idle after done", {31'd0, busy_o}, 32'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1
      check("R1 valid at reset", {31'd0, cyc_valid_o}, 32'd0);
      check("R1 done at reset", {31'd0, done_o}, 32'd0);
      check("R1 busy at reset", {31'd0, busy_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int combo = 0; combo < 32; combo++) begin
         for (int ap = 0; ap < 2; ap++) begin
            for (int mode = 0; mode < 3; mode++) begin
               logic [23:0] a;
               a = (ap == 0) ? 24'hC3A51E : 24'(combo * 24'h0B1D37 + 24'h123456);
               run_req(combo[0], combo[1], combo[2], combo[3], combo[4], a, mode);
            end
         end
      end
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule